// File: doc/BRIEF.md
# Carry-Save Modulo Adder

This block adds two residues modulo a configurable modulus m. No carry propagates along the word anywhere in the block. Each operand enters as a pair of N-bit vectors, a sum vector and a carry vector. The operand's value is the total of its two vectors, and any pair whose total is congruent to the intended residue is valid. A plain binary value enters as (value, 0). The result leaves in the same paired form, so it can feed further modular additions directly. A single carry-propagate stage further downstream turns the final pair into binary.

The block has five pipeline stages. Each stage performs at most one 3:2 compression. The first two stages always compress, merging the four input vectors into one pair. Each compression can produce a carry out of bit N-1, and the block drops that carry. Every dropped carry is owed back as the constant 2^N - m, which is congruent to the dropped weight 2^N. The correction stages clear the debt. If two carries are owed after the merge, the first correction injects 2·(2^N - m) in one step. If a correction throws off a carry of its own, the next stage adds 2^N - m again. Once nothing is owed, the remaining stages pass the pair through unchanged. The two constants are computed outside the block and presented as quasi-static inputs.

Top module: `csmod_adder`

## Requirements
- R1: For every valid result, (res_sum + res_carry) mod m equals (a_sum + a_carry + b_sum + b_carry) mod m.
- R2: res_valid rises exactly five clock cycles after the cycle in which in_valid was sampled high, and each stage's valid follows its predecessor by one cycle.
- R3: A new operation may be accepted in every cycle. Results leave in issue order, one result per accepted operation.
- R4: Every operation completes within five compressions. res_steps (the number of compressions performed) lies in 2..5, and no dropped carry is still owed at the output.
- R5: When nothing is owed, later stages pass the pair unchanged. For the operands A = (x, 0) and B = (0, 0) the result is exactly res_sum = x, res_carry = 0 and res_steps = 2.
- R6: An active-low reset clears every stage's valid flag. Operations in flight at reset never produce a result.
- R7: The constants satisfy k_one = 2^N - m with 2^(N-1) < m <= 2^N, so k_one's top bit is 0, and k_two = 2·k_one. Both constants stay stable while stages 1 to 4 hold a valid operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the valid flags |
| in_valid | input | 1 | Operands are presented this cycle |
| a_sum | input | N | Sum vector of operand A |
| a_carry | input | N | Carry vector of operand A |
| b_sum | input | N | Sum vector of operand B |
| b_carry | input | N | Carry vector of operand B |
| k_one | input | N | Correction constant 2^N - m |
| k_two | input | N | Correction constant 2·(2^N - m) |
| res_valid | output | 1 | Result pair is valid |
| res_sum | output | N | Result sum vector |
| res_carry | output | N | Result carry vector |
| res_steps | output | 3 | Number of compressions the operation used |

## Verification
A wrong owed count or a wrong constant choice shows up on the same cycle the operation leaves stage five. The reduced total of res_sum and res_carry no longer matches the reduced operand total, or res_steps falls outside 2..5. A lost or duplicated valid flag either breaks the exact five-cycle spacing between issue and result or leaves the count of issued and returned operations unequal once the pipe drains. A stage that alters a pair it should pass through corrupts the zero-operand case at once. That case is checked bit for bit, not only modulo m.

// File: rtl/csmod_pkg.sv
package csmod_pkg;
   localparam int NUM_STEPS = 5;
   localparam int STEP_W    = 3;
   localparam int OWED_W    = 2;

   typedef logic [STEP_W-1:0] steps_t;
   typedef logic [OWED_W-1:0] owed_t;
endpackage

// File: rtl/csmod_csa3.sv
module csmod_csa3 #(
   parameter int N = 12
) (
   input  logic [N-1:0] x,
   input  logic [N-1:0] y,
   input  logic [N-1:0] z,
   output logic [N-1:0] s,
   output logic [N-1:0] c_low,
   output logic         ovf
);
   logic [N-1:0] maj;

   for (genvar i = 0; i < N; i++) begin : g_bit
      assign s[i]   = x[i] ^ y[i] ^ z[i];
      assign maj[i] = (x[i] & y[i]) | (x[i] & z[i]) | (y[i] & z[i]);
   end

   // carry vector moves up one place, zero enters at bit 0; the bit
   // leaving the word is reported separately
   assign c_low = {maj[N-2:0], 1'b0};
   assign ovf   = maj[N-1];

   // the compressor preserves the arithmetic total (R1)
   always_comb begin
      if (!$isunknown({x, y, z})) begin
         p_csa_total_r1: assert (({2'b00, x} + {2'b00, y} + {2'b00, z}) ==
                                 ({2'b00, s} + {2'b00, c_low} + {1'b0, ovf, {N{1'b0}}}));
      end
   end
endmodule

// File: rtl/csmod_step.sv
module csmod_step
   import csmod_pkg::*;
#(
   parameter int N = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_vld,
   input  logic         go,
   input  logic [N-1:0] in_s,
   input  logic [N-1:0] in_c,
   input  logic [N-1:0] in_x,
   input  owed_t        owed_base,
   input  steps_t       in_steps,
   output logic         out_vld,
   output logic [N-1:0] out_s,
   output logic [N-1:0] out_c,
   output owed_t        out_owed,
   output steps_t       out_steps
);
   logic [N-1:0] cs_s;
   logic [N-1:0] cs_c;
   logic         cs_ovf;

   csmod_csa3 #(.N(N)) u_csa (
      .x     (in_s),
      .y     (in_c),
      .z     (in_x),
      .s     (cs_s),
      .c_low (cs_c),
      .ovf   (cs_ovf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_vld <= 1'b0;
      else        out_vld <= in_vld;
   end

   always_ff @(posedge clk) begin
      if (go) begin
         out_s     <= cs_s;
         out_c     <= cs_c;
         out_owed  <= owed_base + owed_t'(cs_ovf);
         out_steps <= in_steps + steps_t'(1);
      end else begin
         out_s     <= in_s;
         out_c     <= in_c;
         out_owed  <= owed_base;
         out_steps <= in_steps;
      end
   end

   p_vld_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_vld);
   p_vld_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> !out_vld);
endmodule

// File: rtl/csmod_adder.sv
module csmod_adder
   import csmod_pkg::*;
#(
   parameter int N = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [N-1:0] a_sum,
   input  logic [N-1:0] a_carry,
   input  logic [N-1:0] b_sum,
   input  logic [N-1:0] b_carry,
   input  logic [N-1:0] k_one,
   input  logic [N-1:0] k_two,
   output logic         res_valid,
   output logic [N-1:0] res_sum,
   output logic [N-1:0] res_carry,
   output logic [2:0]   res_steps
);
   localparam int LAST = NUM_STEPS;

   if (N < 2) begin : g_bad_width
      $error("csmod_adder: N must be at least 2");
   end
   if (STEP_W != 3) begin : g_bad_steps
      $error("csmod_adder: step counter width must match res_steps");
   end

   logic [N-1:0] st_s     [0:LAST];
   logic [N-1:0] st_c     [0:LAST];
   owed_t        st_owed  [0:LAST];
   steps_t       st_steps [0:LAST];
   logic         st_vld   [0:LAST];
   logic [N-1:0] bc_q;

   assign st_s[0]     = a_sum;
   assign st_c[0]     = a_carry;
   assign st_owed[0]  = '0;
   assign st_steps[0] = '0;
   assign st_vld[0]   = in_valid;

   // second operand's carry vector joins one stage later
   always_ff @(posedge clk) bc_q <= b_carry;

   for (genvar j = 1; j <= LAST; j++) begin : g_stage
      logic [N-1:0] x_j;
      logic         go_j;
      owed_t        base_j;

      if (j == 1) begin : g_merge_a
         assign x_j    = b_sum;
         assign go_j   = 1'b1;
         assign base_j = st_owed[j-1];
      end else if (j == 2) begin : g_merge_b
         assign x_j    = bc_q;
         assign go_j   = 1'b1;
         assign base_j = st_owed[j-1];
      end else begin : g_fix
         assign x_j    = st_owed[j-1][1] ? k_two : k_one;
         assign go_j   = |st_owed[j-1];
         assign base_j = '0;
      end

      csmod_step #(.N(N)) u_step (
         .clk       (clk),
         .rst_n     (rst_n),
         .in_vld    (st_vld[j-1]),
         .go        (go_j),
         .in_s      (st_s[j-1]),
         .in_c      (st_c[j-1]),
         .in_x      (x_j),
         .owed_base (base_j),
         .in_steps  (st_steps[j-1]),
         .out_vld   (st_vld[j]),
         .out_s     (st_s[j]),
         .out_c     (st_c[j]),
         .out_owed  (st_owed[j]),
         .out_steps (st_steps[j])
      );
   end

   assign res_valid = st_vld[LAST];
   assign res_sum   = st_s[LAST];
   assign res_carry = st_c[LAST];
   assign res_steps = st_steps[LAST];

   // nothing owed leaves the pipe (R4)
   p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (st_owed[LAST] == '0));
   p_step_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_steps >= 3'd2 && res_steps <= 3'd5));

   // a finished pair travels untouched (R5)
   for (genvar j = 2; j < LAST; j++) begin : g_pass_chk
      p_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (st_vld[j] && st_owed[j] == '0) |=>
            (st_s[j+1] == $past(st_s[j]) && st_c[j+1] == $past(st_c[j]) &&
             st_steps[j+1] == $past(st_steps[j])));
   end

   // constant contract (R7)
   p_kpair_r7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> (k_two == {k_one[N-2:0], 1'b0} && !k_one[N-1]));
   p_kstable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_vld[1] || st_vld[2] || st_vld[3] || st_vld[4]) |->
         ($stable(k_one) && $stable(k_two)));
endmodule

// File: tb/csmod_adder_tb_top.sv
module csmod_adder_tb_top;
   localparam int N          = 12;
   localparam int CLK_PERIOD = 10;
   localparam int LAT        = 5;
   localparam int NV         = 18;
   localparam int TOP        = 1 << N;

   // {a_sum, a_carry, b_sum, b_carry, m}
   localparam int VT [0:NV-1][0:4] = '{
      '{1272, 0, 450, 0, 2050},
      '{4095, 4095, 4095, 4095, 2050},
      '{2049, 2049, 2049, 2049, 2050},
      '{0, 0, 0, 0, 2050},
      '{1234, 0, 0, 0, 2050},
      '{2047, 2048, 1, 4095, 2050},
      '{4095, 4095, 4095, 4095, 4095},
      '{4094, 1, 4094, 1, 4095},
      '{100, 200, 300, 400, 4095},
      '{4095, 0, 0, 0, 4095},
      '{4095, 4095, 4095, 4095, 4096},
      '{3000, 3000, 0, 1, 4096},
      '{4095, 4095, 4095, 4095, 2049},
      '{2048, 2048, 2048, 2048, 2049},
      '{3, 5, 7, 11, 2049},
      '{2730, 2730, 2730, 2730, 2731},
      '{1365, 2730, 4095, 2048, 2731},
      '{2731, 0, 0, 0, 2731}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [N-1:0] a_sum = '0, a_carry = '0, b_sum = '0, b_carry = '0;
   logic [N-1:0] k_one = '0, k_two = '0;
   logic         res_valid;
   logic [N-1:0] res_sum, res_carry;
   logic [2:0]   res_steps;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   int issued = 0;
   int returned = 0;
   int cur_m = 0;

   int q_m[$], q_exp[$], q_t[$], q_x[$];
   bit q_ex[$];

   csmod_adder #(.N(N)) dut_i (
      .clk, .rst_n, .in_valid, .a_sum, .a_carry, .b_sum, .b_carry,
      .k_one, .k_two, .res_valid, .res_sum, .res_carry, .res_steps
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // result monitor
   always @(negedge clk) begin
      if (rst_n && res_valid) begin
         returned++;
         if (q_m.size() == 0) begin
            check(1'b0, "R3 unexpected result", 1, 0);
         end else begin
            int m, e, t, x;
            bit ex;
            m = q_m.pop_front(); e = q_exp.pop_front(); t = q_t.pop_front();
            x = q_x.pop_front(); ex = q_ex.pop_front();
            check(((int'(res_sum) + int'(res_carry)) % m) == e, "R1 residue",
                  (int'(res_sum) + int'(res_carry)) % m, e);
            check(cyc - t == LAT, "R2 latency", cyc - t, LAT);
            check(res_steps >= 3'd2 && res_steps <= 3'd5, "R4 step count", res_steps, 5);
            if (ex) begin
               check(res_sum == N'(x) && res_carry == '0, "R5 exact pass-through sum",
                     res_sum, x);
               check(res_steps == 3'd2, "R5 step count", res_steps, 2);
            end
         end
      end
   end

   task automatic set_mod(input int m);
      while (q_m.size() != 0) @(negedge clk);
      k_one = N'(TOP - m);
      k_two = N'(2 * (TOP - m));
      cur_m = m;
   endtask

   task automatic issue(input int as, input int ac, input int bs, input int bc);
      @(negedge clk);
      a_sum = N'(as); a_carry = N'(ac); b_sum = N'(bs); b_carry = N'(bc);
      in_valid = 1'b1;
      issued++;
      q_m.push_back(cur_m);
      q_exp.push_back((as + ac + bs + bc) % cur_m);
      q_t.push_back(cyc);
      q_x.push_back(as);
      q_ex.push_back(ac == 0 && bs == 0 && bc == 0);
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      check(1'b0, "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int mods[4] = '{2049, 3001, 4093, 4096};
      // reset state (R6)
      repeat (3) @(negedge clk);
      check(res_valid == 1'b0, "R6 valid low in reset", res_valid, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(res_valid == 1'b0, "R6 valid low after reset", res_valid, 0);

      // table, back-to-back within one modulus (R1, R2, R3, R5)
      for (int i = 0; i < NV; i++) begin
         if (VT[i][4] != cur_m) begin
            idle();
            set_mod(VT[i][4]);
         end
         issue(VT[i][0], VT[i][1], VT[i][2], VT[i][3]);
      end
      idle();
      set_mod(cur_m);

      // random operands at several moduli, including near 2^N (R1, R3, R4)
      foreach (mods[mi]) begin
         set_mod(mods[mi]);
         for (int r = 0; r < 200; r++) begin
            issue($urandom_range(0, TOP - 1), $urandom_range(0, TOP - 1),
                  $urandom_range(0, TOP - 1), $urandom_range(0, TOP - 1));
         end
         idle();
      end
      set_mod(cur_m);
      repeat (2) @(negedge clk);
      check(issued == returned, "R3 one result per operation", returned, issued);

      // reset with operations in flight (R6)
      issue(4095, 4095, 4095, 4095);
      issue(17, 0, 0, 0);
      idle();
      rst_n = 1'b0;
      q_m.delete(); q_exp.delete(); q_t.delete(); q_x.delete(); q_ex.delete();
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int w = 0; w < 8; w++) begin
         @(negedge clk);
         check(res_valid == 1'b0, "R6 flushed operation stays silent", res_valid, 0);
      end

      // exact pass-through after reset (R5)
      issue(1234, 0, 0, 0);
      idle();
      set_mod(cur_m);
      repeat (2) @(negedge clk);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule